// File: doc/BRIEF.md
# Rotating Priority Resolver

This block is the decision core of an eight-input interrupt controller. It receives the pending-request, mask and in-service vectors held elsewhere in the controller, together with a 3-bit rotating priority base and a flag that removes the cascade input from the nesting comparison. It returns a valid flag and the number of the input that should be presented to the processor.

Priority is relative to the base. The input equal to the base is the most urgent, and urgency falls off going upward with wrap-around. A pending, unmasked request is granted only when it strictly outranks the most urgent input already in service. The block is purely combinational. Register storage, command decoding and acknowledge sequencing belong to the surrounding controller.

Top module: `rot_prio_resolver`

## Requirements
- R1: The candidate set is `req_vec AND NOT mask_vec`. A request whose mask bit is 1 never becomes the granted input.
- R2: When the candidate set is empty, `grant_valid` is 0 and `grant_id` is 0.
- R3: The priority level of input n is (n - prio_base) mod 8, and level 0 is the most urgent. Among the candidates, the one with the smallest level is selected.
- R4: The current in-service level is the smallest level among the set bits of `isr_vec`. It is 8 (none) when no bit counts, so any candidate can then be granted.
- R5: A candidate is granted only when its level is strictly less than the current in-service level. An equal or larger level gives `grant_valid` = 0 and `grant_id` = 0.
- R6: When `skip_cascade` is 1, bit 2 of `isr_vec` is left out of the current-level calculation. When `skip_cascade` is 0, that bit counts like any other.
- R7: When `grant_valid` is 1, `grant_id` is the actual input number, (level + prio_base) mod 8. Bit i of every vector belongs to input i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vec | input | 8 | Pending requests, bit i = input i |
| mask_vec | input | 8 | Mask, 1 blocks the input |
| isr_vec | input | 8 | Inputs currently in service |
| prio_base | input | 3 | Input number holding level 0 |
| skip_cascade | input | 1 | 1 removes cascade bit 2 from the in-service check |
| grant_valid | output | 1 | A request outranks everything in service |
| grant_id | output | 3 | Granted input number, 0 when not valid |

## Verification
The bench builds the resolver with its default parameters: eight inputs, a 3-bit base and the cascade input at position 2. With these values the rotation wraps at exactly the point the controller needs. Every base value can be swept exhaustively against a level-by-level reference loop. Directed cases cover equal-level blocking and the cascade exclusion in both flag states, and random vectors are applied under all eight bases.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    // Default geometry of the resolver
    parameter int unsigned RPR_INPUTS      = 8;
    parameter int unsigned RPR_CASCADE_BIT = 2;

    typedef struct packed {
        logic       valid;
        logic [2:0] id;
    } rpr_grant_t;
endpackage

// File: rtl/rot_prio_scan.sv
// Finds the smallest priority level among set bits of a vector, where the
// level of bit n is (n - base) mod N_IN. Returns N_IN when the vector is empty.
module rot_prio_scan #(
    parameter int unsigned N_IN = 8,
    localparam int unsigned W   = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] vec,
    input  logic [W-1:0]    base,
    output logic [W:0]      level
);
    logic [N_IN-1:0] rot_d;

    // rot_d[k] holds the bit whose level is k
    for (genvar g = 0; g < N_IN; g++) begin : g_rot
        logic [W-1:0] src_d;
        assign src_d    = base + W'(g);
        assign rot_d[g] = vec[src_d];
    end

    always_comb begin
        level = (W+1)'(N_IN);
        for (int k = N_IN - 1; k >= 0; k--) begin
            if (rot_d[k]) level = (W+1)'(k);
        end
    end

    // R4: empty vector maps to level N_IN, otherwise the level points at a set bit
    always_comb begin
        if (!$isunknown({vec, base})) begin
            p_empty_is_none_r4: assert ((vec == '0) == (level == (W+1)'(N_IN)))
                else $error("scan level/empty mismatch");
            if (vec != '0) begin
                p_level_hits_set_bit_r3: assert (vec[level[W-1:0] + base])
                    else $error("scan level does not address a set bit");
            end
        end
    end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
    import rpr_pkg::*;
#(
    parameter int unsigned N_IN        = RPR_INPUTS,
    parameter int unsigned CASCADE_BIT = RPR_CASCADE_BIT,
    localparam int unsigned W          = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] req_vec,
    input  logic [N_IN-1:0] mask_vec,
    input  logic [N_IN-1:0] isr_vec,
    input  logic [W-1:0]    prio_base,
    input  logic            skip_cascade,
    output logic            grant_valid,
    output logic [W-1:0]    grant_id
);
    logic [N_IN-1:0] cand_d;
    logic [N_IN-1:0] svc_d;
    logic [W:0]      cand_lvl_d;
    logic [W:0]      cur_lvl_d;
    logic            win_d;

    always_comb begin
        cand_d = req_vec & ~mask_vec;
        svc_d  = isr_vec;
        if (skip_cascade) svc_d[CASCADE_BIT] = 1'b0;
    end

    rot_prio_scan #(.N_IN(N_IN)) u_cand_scan (
        .vec   (cand_d),
        .base  (prio_base),
        .level (cand_lvl_d)
    );

    rot_prio_scan #(.N_IN(N_IN)) u_svc_scan (
        .vec   (svc_d),
        .base  (prio_base),
        .level (cur_lvl_d)
    );

    always_comb begin
        win_d       = cand_lvl_d < cur_lvl_d;
        grant_valid = win_d;
        grant_id    = win_d ? (cand_lvl_d[W-1:0] + prio_base) : '0;
    end

    always_comb begin
        if (!$isunknown({req_vec, mask_vec, isr_vec, prio_base, skip_cascade})) begin
            // R1: the granted input is requested and unmasked
            if (grant_valid) begin
                p_grant_unmasked_r1: assert (req_vec[grant_id] && !mask_vec[grant_id])
                    else $error("granted input is masked or idle");
            end
            // R2: nothing to grant without an unmasked request
            if ((req_vec & ~mask_vec) == '0) begin
                p_no_cand_no_grant_r2: assert (!grant_valid && grant_id == '0)
                    else $error("grant with empty candidate set");
            end
            // R5: a granted input cannot itself be an in-service input that counts
            if (grant_valid && !(skip_cascade && grant_id == W'(CASCADE_BIT))) begin
                p_grant_not_in_service_r5: assert (!isr_vec[grant_id])
                    else $error("granted input already in service");
            end
            // R6: with no in-service bit besides the excluded cascade, any candidate wins
            if (skip_cascade && (isr_vec & ~(N_IN'(1) << CASCADE_BIT)) == '0
                && (req_vec & ~mask_vec) != '0) begin
                p_cascade_skipped_r6: assert (grant_valid)
                    else $error("excluded cascade bit blocked a grant");
            end
        end
    end
endmodule

// File: tb/rot_prio_resolver_tb.sv
module rot_prio_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_vec = '0, mask_vec = '0, isr_vec = '0;
    logic [2:0] prio_base = '0;
    logic       skip_cascade = 1'b0;
    logic       grant_valid;
    logic [2:0] grant_id;
    int         checks = 0, errors = 0, cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    rot_prio_resolver u_dut (
        .req_vec(req_vec), .mask_vec(mask_vec), .isr_vec(isr_vec),
        .prio_base(prio_base), .skip_cascade(skip_cascade),
        .grant_valid(grant_valid), .grant_id(grant_id)
    );

    // Reference model written from the requirements
    function automatic logic [3:0] ref_level(input logic [7:0] v, input logic [2:0] b);
        for (int l = 0; l < 8; l++) begin
            if (v[3'(b + 3'(l))]) return 4'(l);
        end
        return 4'd8;
    endfunction

    function automatic logic [3:0] ref_grant(input logic [7:0] rq, input logic [7:0] mk,
                                             input logic [7:0] is, input logic [2:0] b,
                                             input logic sk);
        logic [7:0] s = is;
        logic [3:0] cl, sl;
        if (sk) s[2] = 1'b0;
        cl = ref_level(rq & ~mk, b);
        sl = ref_level(s, b);
        if (cl < sl) return {1'b1, 3'(cl[2:0] + b)};
        return 4'b0000;
    endfunction

    task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input logic [7:0] is,
                         input logic [2:0] b, input logic sk);
        @(negedge clk);
        req_vec = rq; mask_vec = mk; isr_vec = is; prio_base = b; skip_cascade = sk;
        #5;
    endtask

    task automatic expect_out(input string req, input logic ev, input logic [2:0] eid);
        checks++;
        if (grant_valid !== ev || grant_id !== eid) begin
            errors++;
            $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                     req, grant_valid, grant_id, ev, eid);
        end
    endtask

    task automatic check_ref(input string req);
        logic [3:0] e = ref_grant(req_vec, mask_vec, isr_vec, prio_base, skip_cascade);
        expect_out(req, e[3], e[2:0]);
    endtask

    task automatic t_idle();                 // R2
        apply(8'h00, 8'h00, 8'h00, 3'd0, 1'b0);
        expect_out("R2 idle", 1'b0, 3'd0);
        apply(8'hFF, 8'hFF, 8'h00, 3'd5, 1'b0);
        expect_out("R2 all masked", 1'b0, 3'd0);
    endtask

    task automatic t_mask();                 // R1
        apply(8'b0001_1000, 8'b0000_1000, 8'h00, 3'd0, 1'b0);
        expect_out("R1 masked 3 skipped", 1'b1, 3'd4);
        apply(8'b1000_0001, 8'b0000_0001, 8'h00, 3'd0, 1'b0);
        expect_out("R1 masked 0 skipped", 1'b1, 3'd7);
    endtask

    task automatic t_rotation();             // R3, R7
        apply(8'b0100_0010, 8'h00, 8'h00, 3'd0, 1'b0);
        expect_out("R3 base0", 1'b1, 3'd1);
        apply(8'b0100_0010, 8'h00, 8'h00, 3'd3, 1'b0);
        expect_out("R3 base3", 1'b1, 3'd6);
        apply(8'b0100_0010, 8'h00, 8'h00, 3'd7, 1'b0);
        expect_out("R7 wrap base7", 1'b1, 3'd1);
        apply(8'hFF, 8'h00, 8'h00, 3'd5, 1'b0);
        expect_out("R7 all pending base5", 1'b1, 3'd5);
    endtask

    task automatic t_nesting();              // R4, R5
        apply(8'b0000_0010, 8'h00, 8'b0000_0010, 3'd0, 1'b0);
        expect_out("R5 equal level blocked", 1'b0, 3'd0);
        apply(8'b0000_0001, 8'h00, 8'b0000_0010, 3'd0, 1'b0);
        expect_out("R5 higher preempts", 1'b1, 3'd0);
        apply(8'b0001_0000, 8'h00, 8'b0000_0010, 3'd0, 1'b0);
        expect_out("R4 lower blocked", 1'b0, 3'd0);
        apply(8'b0000_0001, 8'h00, 8'b0000_0010, 3'd1, 1'b0);
        expect_out("R4 rotated base blocks 0", 1'b0, 3'd0);
    endtask

    task automatic t_cascade();              // R6
        apply(8'b0001_0000, 8'h00, 8'b0000_0100, 3'd0, 1'b0);
        expect_out("R6 cascade counts", 1'b0, 3'd0);
        apply(8'b0001_0000, 8'h00, 8'b0000_0100, 3'd0, 1'b1);
        expect_out("R6 cascade skipped", 1'b1, 3'd4);
        apply(8'b0000_0100, 8'h00, 8'b0000_0100, 3'd0, 1'b1);
        expect_out("R6 cascade re-request", 1'b1, 3'd2);
        apply(8'b0001_0000, 8'h00, 8'b0000_0110, 3'd0, 1'b1);
        expect_out("R6 other bit still counts", 1'b0, 3'd0);
    endtask

    task automatic t_random();               // R1..R7 against the reference
        for (int b = 0; b < 8; b++) begin
            for (int n = 0; n < 300; n++) begin
                apply(8'($urandom), 8'($urandom & $urandom), 8'($urandom & $urandom),
                      3'(b), 1'($urandom));
                check_ref("R3 R5 R7 random sweep");
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: got %0d cycles, expected fewer", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #5 expect_out("R2 reset state", 1'b0, 3'd0);
        t_idle();
        t_mask();
        t_rotation();
        t_nesting();
        t_cascade();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule